// File: doc/BRIEF.md
# Row-Buffered Streaming Dot-Product Unit

This block accelerates matrix products by holding a group of rows of the left-hand matrix A close to a set of multiply-accumulate lanes. First the A rows are written in over a single 32-bit input stream. After that, each column of the right-hand matrix B arrives one element per accepted word. Every incoming B element goes to all lanes in the same cycle. Lane i multiplies the element by its own stored coefficient A[i][k] and adds the product to a running sum. Each result element C[i][j] comes from its own lane, so it is computed independently of the others.

When the last element of a column has been taken, the unit stops accepting input. It then sends out one 32-bit result per resident row on the output stream, row 0 first, and clears every lane so that the next column starts from zero. One column of B therefore yields a complete vertical strip of C. The same A rows remain in place for as many columns as the user sends. A fresh set of A rows may be loaded only between columns.

The sideband flag `in_is_a` selects what an accepted word means, and only when the unit sits between columns. Parameters set the number of resident rows (`ROWS`) and the vector length (`LEN`). Both must be at least 2.

Top module: `strip_mac_engine`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every lane sum is zero, so the first column after reset yields exact dot products.
- R2: Between columns, an accepted word with `in_is_a`=1 starts a load of ROWS·LEN words in row-major order: accepted word number r·LEN+k becomes A[r][k]. The `in_is_a` value of the remaining ROWS·LEN−1 words of that load is ignored.
- R3: Between columns, an accepted word with `in_is_a`=0 is element 0 of a B column. Each accepted element k makes every lane i add A[i][k]·b. The operands are 32-bit two's-complement values, and the sum is held 64 bits wide.
- R4: The LEN-th element is accepted at a clock edge. From the next cycle on, `out_valid` is 1 for exactly ROWS consecutive cycles, and `out_data` carries the result for row 0, 1, … in that order.
- R5: `in_ready` is 0 in every cycle in which `out_valid` is 1. Words offered with `in_valid`=1 in those cycles are not taken.
- R6: All lane sums are zero after the last result of a column, so the next column does not include earlier products.
- R7: Inside a column (after element 0 and before element LEN−1 has been taken), `in_is_a` is ignored, and every accepted word is a B element.
- R8: Stored A rows stay in place across any number of columns. A new load that is started between columns replaces them completely.
- R9: A cycle with `in_valid`=0 changes nothing, whatever `in_data` and `in_is_a` carry.
- R10: Each output word is the low 32 bits of the 64-bit sum. A sum that overflows 32 bits wraps rather than saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_is_a | input | 1 | Between columns: 1 starts an A load, 0 starts a B column |
| in_data | input | 32 | Input word (A coefficient or B element) |
| in_ready | output | 1 | Unit takes a word this cycle if `in_valid` is 1 |
| out_valid | output | 1 | Result word present |
| out_data | output | 32 | Result C[i][j], low 32 bits of the lane sum |

## Verification
Several properties are checked on every cycle:
- Writes to the row store and lane updates never happen in the same cycle.
- Each written coefficient lands at the addressed row and position.
- A result burst starts only directly after a lane update, and its row index steps up by one each cycle.
- All lane sums are zero when the burst ends.

Only the bench scenarios can show that the numbers are right. These scenarios cover:
- the row-major placement of A;
- the signed products and the wrap on overflow;
- that the flag is ignored during a load and inside a column;
- that idle cycles and words offered during the burst have no effect;
- that A persists across columns and a reload replaces it.

// File: rtl/strip_pkg.sv
package strip_pkg;

    localparam int WORD_W = 32;
    localparam int ACC_W  = 64;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        PH_READY = 2'd0,
        PH_LOAD  = 2'd1,
        PH_COL   = 2'd2,
        PH_EMIT  = 2'd3
    } phase_t;

    typedef struct packed {
        logic mac_en;
        logic clr;
    } lane_cmd_t;

    function automatic word_t acc_to_word(input acc_t a);
        return a[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/strip_row_store.sv
module strip_row_store
    import strip_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int LEN  = 4,
    localparam int RW  = $clog2(ROWS),
    localparam int KW  = $clog2(LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_row,
    input  logic [KW-1:0]            wr_col,
    input  word_t                    wdata,
    input  logic [KW-1:0]            rd_col,
    output logic [ROWS-1:0][WORD_W-1:0] col_vals
);

    word_t mem [ROWS][LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < LEN; k++)
                    mem[r][k] <= '0;
        end else if (wr_en) begin
            mem[wr_row][wr_col] <= wdata;
        end
    end

    // one coefficient per lane, all from the same column position
    always_comb begin
        for (int r = 0; r < ROWS; r++)
            col_vals[r] = mem[r][rd_col];
    end

    // R2
    store_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_row)][$past(wr_col)] == $past(wdata));

endmodule

// File: rtl/strip_mac_lane.sv
module strip_mac_lane
    import strip_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cmd_t cmd,
    input  word_t     coef,
    input  word_t     b_elem,
    output acc_t      acc_q
);

    acc_t prod;

    always_comb prod = acc_t'(coef) * acc_t'(b_elem);

    always_ff @(posedge clk) begin
        if (rst || cmd.clr)
            acc_q <= '0;
        else if (cmd.mac_en)
            acc_q <= acc_q + prod;
    end

endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl
    import strip_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int LEN  = 4,
    localparam int RW  = $clog2(ROWS),
    localparam int KW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_is_a,
    output logic          in_ready,
    output logic          wr_en,
    output logic [RW-1:0] wr_row,
    output logic [KW-1:0] col_idx,
    output lane_cmd_t     cmd,
    output logic          emit_valid,
    output logic [RW-1:0] emit_idx
);

    phase_t        phase_q;
    logic [RW-1:0] row_q;
    logic [KW-1:0] col_q;
    logic [RW-1:0] emit_q;
    logic          accept;
    logic          last_col;
    logic          last_row;
    logic          last_emit;

    always_comb begin
        in_ready   = (phase_q != PH_EMIT);
        accept     = in_valid && in_ready;
        last_col   = (col_q == KW'(LEN - 1));
        last_row   = (row_q == RW'(ROWS - 1));
        last_emit  = (emit_q == RW'(ROWS - 1));
        wr_en      = accept && ((phase_q == PH_LOAD) ||
                                (phase_q == PH_READY && in_is_a));
        cmd.mac_en = accept && ((phase_q == PH_COL) ||
                                (phase_q == PH_READY && !in_is_a));
        cmd.clr    = (phase_q == PH_EMIT) && last_emit;
        wr_row     = row_q;
        col_idx    = col_q;
        emit_valid = (phase_q == PH_EMIT);
        emit_idx   = emit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_READY;
            row_q   <= '0;
            col_q   <= '0;
            emit_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_READY: begin
                    if (accept) begin
                        col_q   <= KW'(1);
                        phase_q <= in_is_a ? PH_LOAD : PH_COL;
                    end
                end
                PH_LOAD: begin
                    if (accept) begin
                        if (last_col) begin
                            col_q <= '0;
                            if (last_row) begin
                                row_q   <= '0;
                                phase_q <= PH_READY;
                            end else begin
                                row_q <= row_q + RW'(1);
                            end
                        end else begin
                            col_q <= col_q + KW'(1);
                        end
                    end
                end
                PH_COL: begin
                    if (accept) begin
                        if (last_col) begin
                            col_q   <= '0;
                            emit_q  <= '0;
                            phase_q <= PH_EMIT;
                        end else begin
                            col_q <= col_q + KW'(1);
                        end
                    end
                end
                PH_EMIT: begin
                    if (last_emit) begin
                        emit_q  <= '0;
                        phase_q <= PH_READY;
                    end else begin
                        emit_q <= emit_q + RW'(1);
                    end
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    // R2
    no_wr_mac_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cmd.mac_en));

    // R4
    mac_before_emit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(emit_valid) |-> $past(cmd.mac_en));

    // R4
    emit_order_chk: assert property (@(posedge clk) disable iff (rst)
        (emit_valid && emit_idx != RW'(ROWS - 1))
            |=> (emit_valid && emit_idx == $past(emit_idx) + RW'(1)));

endmodule

// File: rtl/strip_mac_engine.sv
module strip_mac_engine
    import strip_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int LEN  = 4,
    localparam int RW  = $clog2(ROWS),
    localparam int KW  = $clog2(LEN)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_is_a,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [31:0] out_data
);

    logic                        wr_en;
    logic [RW-1:0]               wr_row;
    logic [KW-1:0]               col_idx;
    lane_cmd_t                   cmd;
    logic                        emit_valid;
    logic [RW-1:0]               emit_idx;
    logic [ROWS-1:0][WORD_W-1:0] col_vals;
    acc_t                        lane_acc [ROWS];
    logic                        accs_zero;

    strip_ctrl #(.ROWS(ROWS), .LEN(LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_is_a    (in_is_a),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_row     (wr_row),
        .col_idx    (col_idx),
        .cmd        (cmd),
        .emit_valid (emit_valid),
        .emit_idx   (emit_idx)
    );

    strip_row_store #(.ROWS(ROWS), .LEN(LEN)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_col   (col_idx),
        .wdata    (word_t'(in_data)),
        .rd_col   (col_idx),
        .col_vals (col_vals)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_lane
        strip_mac_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .coef   (word_t'(col_vals[g])),
            .b_elem (word_t'(in_data)),
            .acc_q  (lane_acc[g])
        );
    end

    always_comb begin
        out_valid = emit_valid;
        out_data  = acc_to_word(lane_acc[emit_idx]);
        accs_zero = 1'b1;
        for (int r = 0; r < ROWS; r++)
            if (lane_acc[r] != '0) accs_zero = 1'b0;
    end

    // R6
    acc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> accs_zero);

endmodule

// File: tb/strip_mac_engine_tb.sv
module strip_mac_engine_tb;

    localparam int ROWS = 4;
    localparam int LEN  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_is_a = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    int gap_max = 0;
    bit done = 1'b0;

    int a_m [ROWS][LEN];
    int b_v [LEN];
    logic [31:0] cap [0:63];
    int cap_n = 0;

    always #5 clk = ~clk;

    strip_mac_engine #(.ROWS(ROWS), .LEN(LEN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_a(in_is_a),
        .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // capture results; R5: input never taken while results stream out
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (cap_n < 64) cap[cap_n] = out_data;
            cap_n++;
            chk(!in_ready, "R5 in_ready during emit", 32'(in_ready), 32'd0);
        end
    end

    function automatic logic [31:0] exp_dot(input int i);
        longint s = 0;
        for (int k = 0; k < LEN; k++)
            s += longint'(a_m[i][k]) * longint'(b_v[k]);
        return s[31:0];
    endfunction

    // R9: idle gaps carry random junk with in_valid low
    task automatic put_word(input logic is_a, input logic [31:0] d);
        int gap = (gap_max > 0) ? int'($urandom_range(0, gap_max)) : 0;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_is_a  = 1'($urandom);
            in_data  = $urandom;
        end
        @(negedge clk);
        while (!in_ready) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_is_a  = is_a;
        in_data  = d;
        @(posedge clk);
    endtask

    // R2: only the first word's flag matters, later ones are random
    task automatic load_a();
        for (int r = 0; r < ROWS; r++)
            for (int k = 0; k < LEN; k++)
                put_word((r == 0 && k == 0) ? 1'b1 : 1'($urandom), a_m[r][k]);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_col(input bit mid_a, input bit junk, input string tag);
        cap_n = 0;
        for (int k = 0; k < LEN; k++)
            put_word((k > 0 && mid_a) ? 1'b1 : 1'b0, b_v[k]);
        for (int e = 0; e < ROWS; e++) begin
            @(negedge clk);
            in_valid = junk;
            in_is_a  = 1'b1;
            in_data  = $urandom;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(cap_n == ROWS, {"R4 burst length ", tag}, 32'(cap_n), 32'(ROWS));
        for (int i = 0; i < ROWS; i++)
            chk(cap[i] == exp_dot(i), {"R3/R4/R10 row result ", tag}, cap[i], exp_dot(i));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        // R2 R3 R4 directed: small distinct values
        for (int r = 0; r < ROWS; r++)
            for (int k = 0; k < LEN; k++)
                a_m[r][k] = r * 10 + k + 1;
        load_a();
        for (int k = 0; k < LEN; k++) b_v[k] = k + 1;
        run_col(1'b0, 1'b0, "directed");

        // R6 R8: second column on same A, sums must restart from zero
        for (int k = 0; k < LEN; k++) b_v[k] = -(k * 3) - 2;
        run_col(1'b0, 1'b0, "R6 R8 reuse");

        // R7 flag high inside column, R5 junk offered during burst
        for (int k = 0; k < LEN; k++) b_v[k] = 7 - k;
        run_col(1'b1, 1'b1, "R7 R5 ignored");

        // R10 overflow wrap with extreme values
        for (int r = 0; r < ROWS; r++)
            for (int k = 0; k < LEN; k++)
                a_m[r][k] = (r % 2 == 0) ? 32'h7fffffff : 32'h80000000;
        load_a();
        for (int k = 0; k < LEN; k++) b_v[k] = 32'h7fffffff;
        run_col(1'b0, 1'b0, "R10 wrap");

        // R8 reload and R9 random gaps, random columns
        gap_max = 3;
        for (int rep = 0; rep < 6; rep++) begin
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < LEN; k++)
                    a_m[r][k] = int'($urandom);
            load_a();
            for (int c = 0; c < 4; c++) begin
                for (int k = 0; k < LEN; k++)
                    b_v[k] = (c == 0) ? int'($urandom_range(0, 200)) - 100 : int'($urandom);
                run_col(1'($urandom), 1'($urandom), "R8 R9 random");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule